// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between a single processor thread and a shared memory port and gives the thread total-store-order behaviour. A store from the thread is held in a small circular queue and is not written to memory when it is accepted. A load first looks for a pending store to its address. If one or more are pending, the load returns the value of the youngest one. If none is pending, the load reads memory directly, and it may do so ahead of older pending stores to other addresses.

Pending stores are written to memory strictly in arrival order whenever the port is free and grants a write. A fence is held off until the queue is empty. An atomic compare-and-set is also held off until the queue is empty. It then reads memory, writes the new value only when the old value equals the compare value, and returns the old value. Depth and the address and data widths are parameters.

Top module: `tso_store_queue`

## Requirements
- R1: After synchronous reset, sb_empty=1, sb_full=0, sb_count=0, resp_valid=0 and mem_req=0.
- R2: A store (req_op=1) is accepted while the queue is not full. It raises sb_count by one, and memory is not written while the port grants no writes.
- R3: A load (req_op=0) to an address with pending stores is accepted in the same cycle. resp_data one cycle later holds the value of the youngest pending store to that address.
- R4: A load with no pending store to its address drives a memory read (mem_req=1, mem_we=0) and is accepted in the cycle mem_gnt is high. One cycle later it returns mem_rdata from that cycle.
- R5: Pending stores leave through the memory port as writes in arrival order, one per granted cycle.
- R6: A store presented while sb_count equals DEPTH sees req_ready=0 until an entry has drained.
- R7: A fence (req_op=2) sees req_ready=0 while any store is pending. Once accepted, it gives resp_valid one cycle later.
- R8: A compare-and-set (req_op=3) is accepted only once the queue is empty. It returns the old memory value. The new value req_wdata is stored only when the old value equals req_cmp, and memory is left unchanged otherwise.
- R9: A load that misses the queue takes the memory port ahead of draining, so it completes while older stores to other addresses are still pending.
- R10: sb_count equals the number of pending stores and never exceeds DEPTH. sb_empty is high exactly when sb_count is 0, and sb_full is high exactly when sb_count equals DEPTH.
- R11: Every accepted request produces resp_valid high in exactly the following cycle, and resp_valid is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Thread request present |
| req_op | input | 2 | 0 load, 1 store, 2 fence, 3 compare-and-set |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Store value or compare-and-set new value |
| req_cmp | input | DW | Compare-and-set expected value |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_valid | output | 1 | Registered completion pulse |
| resp_data | output | DW | Load value or compare-and-set old value, zero otherwise |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_gnt | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | DW | Read data for mem_addr, valid with mem_gnt |
| sb_empty | output | 1 | No store pending |
| sb_full | output | 1 | DEPTH stores pending |
| sb_count | output | $clog2(DEPTH+1) | Number of pending stores |

## Verification
Four repeated stores, two of them to the same address, are held in the queue while writes are withheld. Loads then sweep every address, so youngest-match forwarding, older-entry shadowing and memory misses are each seen, and the miss loads finish while the queue stays full. Releasing writes then shows the drain order and the release of a stalled store and a stalled fence. A long alternating store and load sweep over all addresses checks each load against a shadow value. Compare-and-set is tried with a matching and with a mismatching compare value, which separates the write from the no-write case.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_FENCE  = 2'd2,
    OP_ATOMIC = 2'd3
  } sq_op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_AT_RD  = 2'd1,
    ST_AT_WR  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/sq_fifo.sv
module sq_fifo #(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count
);
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[tail_q] <= push_addr;
      data_q[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // Search from oldest to youngest; later matches overwrite earlier ones.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] k;
      k = head_q + PW'(i);
      if ((CW'(i) < count_q) && (addr_q[k] == look_addr)) begin
        hit      = 1'b1;
        hit_data = data_q[k];
      end
    end
  end

  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign count     = count_q;
endmodule

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  sq_op_e        op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_cmp,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  input  logic          q_empty,
  input  logic          q_full,
  input  logic          fwd_hit,
  input  logic [DW-1:0] fwd_data,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  output logic          push,
  output logic          pop,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata
);
  sq_state_e     state_q, state_d;
  logic [DW-1:0] old_q, old_d;
  logic          miss_ld;

  assign miss_ld = req_valid && (op == OP_LOAD) && !fwd_hit;

  always_comb begin
    state_d   = state_q;
    old_d     = old_q;
    req_ready = 1'b0;
    push      = 1'b0;
    pop       = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = req_addr;
    mem_wdata = req_wdata;
    unique case (state_q)
      ST_AT_RD: begin
        mem_req = 1'b1;
        if (mem_gnt) begin
          old_d   = mem_rdata;
          state_d = ST_AT_WR;
        end
      end
      ST_AT_WR: begin
        if (old_q == req_cmp) begin
          mem_req = 1'b1;
          mem_we  = 1'b1;
          if (mem_gnt) begin
            req_ready = 1'b1;
            state_d   = ST_IDLE;
          end
        end else begin
          req_ready = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      default: begin
        if (miss_ld) begin
          mem_req = 1'b1;
        end else if (!q_empty) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = head_addr;
          mem_wdata = head_data;
          pop       = mem_gnt;
        end
        if (req_valid) begin
          unique case (op)
            OP_LOAD:  req_ready = fwd_hit || mem_gnt;
            OP_STORE: begin
              req_ready = !q_full;
              push      = !q_full;
            end
            OP_FENCE: req_ready = q_empty;
            default:  if (q_empty) state_d = ST_AT_RD;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      old_q      <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      state_q    <= state_d;
      old_q      <= old_d;
      resp_valid <= req_valid && req_ready;
      if (req_valid && req_ready) begin
        unique case (op)
          OP_LOAD:   resp_data <= fwd_hit ? fwd_data : mem_rdata;
          OP_ATOMIC: resp_data <= old_q;
          default:   resp_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tso_store_queue.sv
module tso_store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_cmp,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata,
  output logic          sb_empty,
  output logic          sb_full,
  output logic [CW-1:0] sb_count
);
  logic          push, pop, fwd_hit;
  logic [DW-1:0] fwd_data, head_data;
  logic [AW-1:0] head_addr;
  logic [CW-1:0] count;

  sq_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (req_addr),
    .push_data (req_wdata),
    .pop       (pop),
    .look_addr (req_addr),
    .hit       (fwd_hit),
    .hit_data  (fwd_data),
    .head_addr (head_addr),
    .head_data (head_data),
    .count     (count)
  );

  sq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .op         (sq_op_e'(req_op)),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_cmp    (req_cmp),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .q_empty    (sb_empty),
    .q_full     (sb_full),
    .fwd_hit    (fwd_hit),
    .fwd_data   (fwd_data),
    .head_addr  (head_addr),
    .head_data  (head_data),
    .push       (push),
    .pop        (pop),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rdata  (mem_rdata)
  );

  assign sb_count = count;
  assign sb_empty = (count == '0);
  assign sb_full  = (count == CW'(DEPTH));
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic          req_ready,
  input logic          resp_valid,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_gnt,
  input logic          sb_empty,
  input logic          sb_full,
  input logic [CW-1:0] sb_count
);
  logic acc, st_acc, drain;
  assign acc    = req_valid && req_ready;
  assign st_acc = acc && (req_op == 2'd1);
  assign drain  = mem_req && mem_we && mem_gnt && !sb_empty;

  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (sb_full && req_valid && req_op == 2'd1) |-> !req_ready);

  // R7
  fence_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 2'd2) |-> sb_empty);

  // R8
  atomic_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && req_op == 2'd3) |-> sb_empty);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (st_acc && !drain) |=> (sb_count == $past(sb_count) + 1'b1));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sb_count <= CW'(DEPTH));

  // R11
  resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> resp_valid);

  // R11
  resp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> !resp_valid);
endmodule

bind tso_store_queue sq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/tso_store_queue_tb.sv
module tso_store_queue_tb;
  localparam int DEPTH = 4;
  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int NA    = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, req_cmp = '0;
  logic          req_ready, resp_valid, mem_req, mem_we, mem_gnt;
  logic [DW-1:0] resp_data, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          sb_empty, sb_full;
  logic [CW-1:0] sb_count;

  logic          gnt_wr = 1'b0;
  logic          gnt_rd = 1'b1;
  logic [DW-1:0] mem [NA];
  logic [DW-1:0] shadow [NA];
  logic [AW-1:0] log_a [16];
  logic [DW-1:0] log_d [16];
  int            nlog = 0;
  int            errors = 0, checks = 0;

  always #5 clk = ~clk;

  assign mem_gnt   = gnt_wr || (gnt_rd && !mem_we);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_req && mem_we && mem_gnt) begin
      mem[mem_addr] <= mem_wdata;
      if (nlog < 16) begin
        log_a[nlog] <= mem_addr;
        log_d[nlog] <= mem_wdata;
      end
      nlog <= nlog + 1;
    end
  end

  tso_store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [DW-1:0] c,
                       output logic rv, output logic [DW-1:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; req_cmp = c;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    rv = resp_valid;
    r  = resp_data;
  endtask

  task automatic hold_stalled(input logic [1:0] op, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(req_ready == 1'b0, tag, req_ready, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic          rv;
    logic [DW-1:0] r;
    for (int a = 0; a < NA; a++) begin
      mem[a]    = DW'(a * 7 + 3);
      shadow[a] = DW'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 / R10 reset state
    chk(sb_empty && !sb_full && sb_count == 0, "R1 status", sb_count, 0);
    chk(!resp_valid && !mem_req, "R1 outputs", {resp_valid, mem_req}, 0);

    // R2: fill queue with writes withheld
    begin
      logic [AW-1:0] sa [4] = '{3'd1, 3'd2, 3'd1, 3'd3};
      logic [DW-1:0] sd [4] = '{8'd10, 8'd20, 8'd30, 8'd40};
      for (int i = 0; i < 4; i++) begin
        do_op(2'd1, sa[i], sd[i], '0, rv, r);
        shadow[sa[i]] = sd[i];
        chk(sb_count == CW'(i + 1), "R2 count", sb_count, i + 1);
        chk(rv && r == 0, "R11 store resp", rv, 1);
      end
    end
    chk(mem[1] == 8'd10 && mem[2] == 8'd17, "R2 memory untouched", mem[1], 10);
    chk(sb_full && !sb_empty, "R10 full flag", sb_full, 1);

    // R3 / R4 / R9: sweep loads over all addresses with queue full
    for (int a = 0; a < NA; a++) begin
      do_op(2'd0, AW'(a), '0, '0, rv, r);
      chk(rv && r == shadow[a], (a == 1 || a == 2 || a == 3) ? "R3 forward" : "R4 miss",
          r, shadow[a]);
    end
    chk(sb_count == CW'(DEPTH), "R9 loads bypassed pending stores", sb_count, DEPTH);

    // R7: fence stalls while stores pend
    hold_stalled(2'd2, '0, '0, "R7 fence stall");
    req_valid = 1'b0;
    // R6: store stalls when full
    hold_stalled(2'd1, 3'd4, 8'd50, "R6 full stall");
    gnt_wr = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    shadow[4] = 8'd50;
    chk(resp_valid, "R6 store released", resp_valid, 1);
    do_op(2'd2, '0, '0, '0, rv, r);
    chk(rv && sb_empty, "R7 fence done empty", sb_count, 0);
    // R5: drain order
    chk(nlog == 5, "R5 drain count", nlog, 5);
    begin
      logic [AW-1:0] ea [5] = '{3'd1, 3'd2, 3'd1, 3'd3, 3'd4};
      logic [DW-1:0] ed [5] = '{8'd10, 8'd20, 8'd30, 8'd40, 8'd50};
      for (int i = 0; i < 5; i++)
        chk(log_a[i] == ea[i] && log_d[i] == ed[i], "R5 drain order", log_d[i], ed[i]);
    end

    // R3 / R4 / R5: stream of stores and loads with writes granted
    for (int i = 0; i < 64; i++) begin
      logic [AW-1:0] sa2, la;
      sa2 = AW'(i);
      la  = AW'(i * 3);
      do_op(2'd1, sa2, DW'(i * 5 + 1), '0, rv, r);
      shadow[sa2] = DW'(i * 5 + 1);
      do_op(2'd0, la, '0, '0, rv, r);
      chk(rv && r == shadow[la], "R3 stream load", r, shadow[la]);
    end
    do_op(2'd2, '0, '0, '0, rv, r);
    for (int a = 0; a < NA; a++)
      chk(mem[a] == shadow[a], "R5 final memory", mem[a], shadow[a]);

    // R8: compare-and-set waits for empty, then success and failure
    gnt_wr = 1'b0;
    do_op(2'd1, 3'd6, 8'h66, '0, rv, r);
    shadow[6] = 8'h66;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_addr = 3'd6; req_wdata = 8'h77; req_cmp = 8'h66;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!req_ready, "R8 atomic stall", req_ready, 0);
      @(negedge clk);
    end
    gnt_wr = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(resp_valid && resp_data == 8'h66, "R8 success old value", resp_data, 8'h66);
    chk(mem[6] == 8'h77, "R8 success write", mem[6], 8'h77);
    do_op(2'd3, 3'd6, 8'h11, 8'h00, rv, r);
    chk(rv && r == 8'h77, "R8 fail old value", r, 8'h77);
    chk(mem[6] == 8'h77, "R8 fail no write", mem[6], 8'h77);
    @(negedge clk);
    chk(!resp_valid, "R11 idle quiet", resp_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule